// File: doc/BRIEF.md
# Post-FEC Error Location Emulator

This block takes a stream of per-bit error flags, one per received bit, taken from a pattern checker. It works out what a Reed-Solomon block code would have done with those errors, using only where they fall. It never touches the data and never decodes. Bits are grouped into symbols of `SYM_W` bits. Symbols are grouped into codewords of `N_SYM` symbols. A codeword is judged correctable when no more than `T_CORR` of its symbols hold an error.

Three running totals are kept:
- raw errored bits;
- errored bits that the code would have left uncorrected;
- uncorrectable codewords.

The interleaved mode uses `LANES` greater than one. Successive symbols are dealt round-robin to that many independent codeword tallies. This spreads error bursts over several codewords, and the interleaving gives no correction of its own.

A pulse on `align`, given with a valid bit, sets the codeword boundary. Until the first such pulse, the stream is ignored. The parameters select the code. Two examples: 5-bit symbols with n=30, k=26, t=2, or 10-bit symbols with n=528, k=514, t=7.

Top module: `fec_err_tally`

## Requirements
- R1: A symbol counts as one errored symbol whether one or all of its `SYM_W` bits are flagged, so a codeword with `T_CORR` fully errored symbols is still correctable.
- R2: When a codeword completes with at most `T_CORR` errored symbols, `post_cnt` and `uncorr_cnt` are left unchanged.
- R3: When a codeword completes with more than `T_CORR` errored symbols, every flagged bit of that codeword is added to `post_cnt`, and `uncorr_cnt` rises by one.
- R4: `raw_cnt` rises by one for every bit taken with `err_valid`=1 and `err_bit`=1 once aligned. Cycles with `err_valid`=0 change no counter and do not advance the bit position.
- R5: Bits that arrive before the first `align` pulse (given with `err_valid`=1) change no counter and set no position.
- R6: A bit taken with `align`=1 is bit 0 of symbol 0 of lane 0. Any partly filled codewords are dropped without being judged, and their errors stay only in `raw_cnt`.
- R7: With `LANES`=L, symbol j after alignment goes to codeword tally j mod L. Each tally completes after `N_SYM` of its own symbols.
- R8: `clr`=1 sets all three counters to zero on the next cycle and takes precedence over any count in that same cycle. It leaves alignment and partial codewords intact.
- R9: After reset all counters are zero. A counter change caused by a bit appears at the outputs in the cycle after that bit is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| clr | input | 1 | Synchronous clear of the three counters |
| err_valid | input | 1 | A received bit is present this cycle |
| err_bit | input | 1 | That bit was received in error |
| align | input | 1 | This valid bit starts a new codeword set |
| raw_cnt | output | CNT_W | Total flagged bits |
| post_cnt | output | CNT_W | Flagged bits in uncorrectable codewords |
| uncorr_cnt | output | CNT_W | Uncorrectable codewords |

## Verification
Each counter is one register away from its inputs:
- `raw_cnt` moves the cycle after the flagged bit is sampled.
- `post_cnt` and `uncorr_cnt` move the cycle after the last bit of the completing codeword's last symbol.
- `clr` clears the counters one cycle after it is asserted.

The bench drives on the falling edge. It compares the counters on the falling edge after the final bit of each codeword set, by which point every codeword of the set has completed. The single-bit latency check samples exactly one cycle after the bit.

// File: rtl/fec_err_tally.sv
module fec_err_tally #(
  parameter int SYM_W  = 5,
  parameter int N_SYM  = 30,
  parameter int K_SYM  = 26,
  parameter int T_CORR = (N_SYM - K_SYM) / 2,
  parameter int LANES  = 1,
  parameter int CNT_W  = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             err_valid,
  input  logic             err_bit,
  input  logic             align,
  output logic [CNT_W-1:0] raw_cnt,
  output logic [CNT_W-1:0] post_cnt,
  output logic [CNT_W-1:0] uncorr_cnt
);
  localparam int BIT_W = $clog2(SYM_W + 1);
  localparam int IDX_W = $clog2(N_SYM + 1);
  localparam int LN_W  = $clog2(LANES + 1);
  localparam int SE_W  = $clog2(T_CORR + 2);
  localparam int CB_W  = $clog2(N_SYM * SYM_W + 1);

  logic             locked, sym_hit;
  logic [BIT_W-1:0] bit_idx;
  logic [IDX_W-1:0] sym_idx;
  logic [LN_W-1:0]  lane;
  logic [SE_W-1:0]  lane_se   [LANES];
  logic [CB_W-1:0]  lane_bits [LANES];

  logic             take, hit, last_bit, last_sym, last_lane, fire, bad, sat;
  logic [BIT_W-1:0] eb;
  logic [IDX_W-1:0] es;
  logic [LN_W-1:0]  el;
  logic [SE_W-1:0]  cur_se, se_next;
  logic [CB_W-1:0]  cur_bits, bits_next;

  assign take      = err_valid && (align || locked);
  assign eb        = align ? '0 : bit_idx;
  assign es        = align ? '0 : sym_idx;
  assign el        = align ? '0 : lane;
  assign hit       = (sym_hit && !align) || err_bit;
  assign last_bit  = eb == BIT_W'(SYM_W - 1);
  assign last_sym  = es == IDX_W'(N_SYM - 1);
  assign last_lane = el == LN_W'(LANES - 1);

  always_comb begin
    cur_se   = '0;
    cur_bits = '0;
    if (!align)
      for (int l = 0; l < LANES; l++)
        if (lane == LN_W'(l)) begin
          cur_se   = lane_se[l];
          cur_bits = lane_bits[l];
        end
  end

  assign sat       = cur_se == SE_W'(T_CORR + 1);
  assign se_next   = (hit && !sat) ? cur_se + SE_W'(1) : cur_se;
  assign bits_next = cur_bits + CB_W'(err_bit);
  assign fire      = take && last_bit && last_sym;
  assign bad       = se_next > SE_W'(T_CORR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked     <= 1'b0;
      sym_hit    <= 1'b0;
      bit_idx    <= '0;
      sym_idx    <= '0;
      lane       <= '0;
      raw_cnt    <= '0;
      post_cnt   <= '0;
      uncorr_cnt <= '0;
      for (int l = 0; l < LANES; l++) begin
        lane_se[l]   <= '0;
        lane_bits[l] <= '0;
      end
    end else begin
      if (take) begin
        locked  <= 1'b1;
        sym_hit <= last_bit ? 1'b0 : hit;
        bit_idx <= last_bit ? '0 : eb + BIT_W'(1);
        if (last_bit) lane <= last_lane ? '0 : el + LN_W'(1);
        else          lane <= el;
        if (last_bit && last_lane) sym_idx <= last_sym ? '0 : es + IDX_W'(1);
        else                       sym_idx <= es;
        for (int l = 0; l < LANES; l++) begin
          if (el == LN_W'(l)) begin
            if (fire) begin
              lane_se[l]   <= '0;
              lane_bits[l] <= '0;
            end else begin
              lane_bits[l] <= bits_next;
              if (last_bit) lane_se[l] <= se_next;
              else if (align) lane_se[l] <= '0;
            end
          end else if (align) begin
            lane_se[l]   <= '0;
            lane_bits[l] <= '0;
          end
        end
        raw_cnt <= raw_cnt + CNT_W'(err_bit);
        if (fire && bad) begin
          post_cnt   <= post_cnt + CNT_W'(bits_next);
          uncorr_cnt <= uncorr_cnt + CNT_W'(1);
        end
      end
      if (clr) begin
        raw_cnt    <= '0;
        post_cnt   <= '0;
        uncorr_cnt <= '0;
      end
    end
  end
endmodule

// File: rtl/fec_err_tally_chk.sv
module fec_err_tally_chk #(
  parameter int CNT_W = 48
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr,
  input logic             locked,
  input logic [CNT_W-1:0] raw_cnt,
  input logic [CNT_W-1:0] post_cnt,
  input logic [CNT_W-1:0] uncorr_cnt
);
  // R4
  raw_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (raw_cnt - $past(raw_cnt)) <= CNT_W'(1));

  // R3
  post_pairs_uncorr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((post_cnt != $past(post_cnt)) == (uncorr_cnt == $past(uncorr_cnt) + CNT_W'(1))));

  // R8
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (raw_cnt == '0 && post_cnt == '0 && uncorr_cnt == '0));

  // R5
  prelock_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> (raw_cnt == '0 && post_cnt == '0 && uncorr_cnt == '0));

  // R2
  uncorr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (uncorr_cnt - $past(uncorr_cnt)) <= CNT_W'(1));
endmodule

bind fec_err_tally fec_err_tally_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/fec_err_tally_bench.sv
`timescale 1ns/1ps
module fec_err_tally_bench;
  localparam int SW = 3, NS = 4, KS = 2, TC = 1, LN = 2, CW = 48;
  localparam int SET = SW * NS * LN;

  logic clk = 0, rst_n = 0, clr = 0, err_valid = 0, err_bit = 0, align = 0;
  logic [CW-1:0] raw_cnt, post_cnt, uncorr_cnt;
  longint e_raw = 0, e_post = 0, e_unc = 0;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  fec_err_tally #(.SYM_W(SW), .N_SYM(NS), .K_SYM(KS), .T_CORR(TC), .LANES(LN), .CNT_W(CW))
    u_fec_err_tally (.*);

  always #2.5 clk = ~clk;

  task automatic chk(string tag, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send(logic e, logic a);
    @(negedge clk); err_valid = 1; err_bit = e; align = a;
  endtask

  task automatic idle();
    @(negedge clk); err_valid = 0; err_bit = 0; align = 0; clr = 0;
  endtask

  task automatic check_all(string tag);
    chk({tag, " raw"}, longint'(raw_cnt), e_raw);
    chk({tag, " post"}, longint'(post_cnt), e_post);
    chk({tag, " uncorr"}, longint'(uncorr_cnt), e_unc);
  endtask

  task automatic judge(logic [SET-1:0] p);
    for (int l = 0; l < LN; l++) begin
      int syms = 0, bits = 0;
      for (int s = 0; s < NS; s++) begin
        int j = s * LN + l;
        int c = 0;
        for (int b = 0; b < SW; b++) c += p[j*SW+b];
        bits += c;
        if (c > 0) syms++;
      end
      if (syms > TC) begin e_post += bits; e_unc++; end
    end
    for (int i = 0; i < SET; i++) e_raw += p[i];
  endtask

  task automatic run_set(logic [SET-1:0] p, logic a, string tag);
    for (int i = 0; i < SET; i++) send(p[i], a && i == 0);
    judge(p);
    idle();
    check_all(tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_all("R9 reset");

    // R5: flagged bits before alignment
    for (int i = 0; i < 10; i++) send(1, 0);
    idle();
    check_all("R5 prealign");

    // R9: one-cycle latency of raw count
    send(1, 1);
    @(negedge clk);
    chk("R9 latency raw", longint'(raw_cnt), 1);
    err_valid = 0; err_bit = 0; align = 0;
    e_raw = 1;

    // R6: partial codewords with heavy errors are dropped on realign
    for (int i = 0; i < 11; i++) send(1, 0);
    e_raw += 11;
    run_set('0, 1, "R6 realign");

    // R7 / R2 / R3: exhaustive symbol error masks, one bit per symbol
    for (int m = 0; m < 256; m++) begin
      logic [SET-1:0] p = '0;
      for (int j = 0; j < NS * LN; j++)
        if (m[j]) p[j*SW + ((m + j) % SW)] = 1'b1;
      run_set(p, 0, "R7 mask sweep");
    end

    // R1: fully errored symbols, at most TC per lane, stay correctable
    run_set({SW{1'b1}} | ({SW{1'b1}} << SW), 0, "R1 full symbols");
    chk("R1 no uncorr", longint'(uncorr_cnt), e_unc);

    // R3: every bit errored
    run_set('1, 0, "R3 all errored");

    // R4: valid low cycles leave counters and position alone
    for (int i = 0; i < 7; i++) begin
      @(negedge clk); err_valid = 0; err_bit = 1;
    end
    idle();
    check_all("R4 valid low");
    run_set(24'h00_0c0a, 0, "R4 after gap");

    // R2 / R3: dense pseudo-random patterns
    for (int r = 0; r < 64; r++) begin
      logic [31:0] h = (r + 1) * 32'h9E37_79B1;
      logic [SET-1:0] p = SET'(h ^ (h >> 7)) & SET'(h >> 3);
      run_set(p, 0, "R3 random");
    end

    // R8: clear between sets, then clear together with a flagged bit
    @(negedge clk); clr = 1;
    idle();
    e_raw = 0; e_post = 0; e_unc = 0;
    check_all("R8 clear");
    @(negedge clk); err_valid = 1; err_bit = 1; align = 1; clr = 1;
    for (int i = 1; i < SET; i++) begin
      @(negedge clk); clr = 0; align = 0; err_bit = 0;
    end
    idle();
    check_all("R8 clear wins");

    run_set(24'hff_0000, 1, "R6 aligned restart");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R9 actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule